// File: doc/BRIEF.md
# Multichannel Gain, Trim and Slot Router

This block is the last per-sample stage ahead of the serial audio outputs. It accepts a frame of sixteen signed 32-bit internal channels together with a one-cycle frame strobe. It scales every channel by a shared signed gain and by that channel's own unsigned trim, and it can silence the whole frame with a mute control. It then fills a set of output slots, each taking whichever internal channel its selector names. Several slots may share one channel.

A dual-mono front stage sits ahead of the scaling. It can replace the center channel (internal channel 1) with the left input (channel 0), the right input (channel 2) or their average, and in those modes it silences left and right. All control values are sampled together with the frame they apply to, so a frame never mixes old and new settings. The register bus that holds these values, coefficient ramping and serial formatting sit outside the block.

Top module: `chan_trim_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` becomes 0 and every slot of `out_samples` becomes 0.
- R2: Each `in_valid` pulse produces one `out_valid` pulse exactly three clock edges later. Back-to-back frames give back-to-back outputs.
- R3: Each channel is scaled to round(x * g * t / 2^58), with exact halves rounded upward. Here x is the signed sample, g is the signed gain with 27 fraction bits (0x08000000 = 1.0) and t is the unsigned trim with 31 fraction bits (0x80000000 = 1.0, 0x00000000 = 0.0). The product is kept at full precision until this rounding.
- R4: A negative gain inverts polarity: gain 0xF8000000 (-1.0) turns 1000 into -1000.
- R5: A scaled result above 0x7FFFFFFF saturates to 0x7FFFFFFF, and one below -2^31 saturates to 0x80000000.
- R6: When `cfg_gain_en` is 0 the gain is treated as exactly 1.0 whatever `cfg_gain` holds, and the trims still apply.
- R7: When `cfg_mute` is 1 every output slot carries 0 for that frame.
- R8: When `cfg_remap_en` is 1, slot k carries the scaled channel numbered by `cfg_route[4k+3:4k]`. Any number of slots may name the same channel.
- R9: When `cfg_remap_en` is 0, slot k carries scaled channel k and `cfg_route` has no effect.
- R10: `cfg_dual_mono` code 0 passes channels unchanged. Code 1 copies channel 0 into channel 1, code 2 copies channel 2 into channel 1, and code 3 puts floor((ch0 + ch2) / 2) into channel 1 without overflow. Codes 1 to 3 also force channels 0 and 2 to zero. All of this happens before scaling.
- R11: Every `cfg_*` value is captured only on a clock edge where `in_valid` is 1. Changing a setting while a frame is in flight does not alter that frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame strobe, one cycle per frame |
| in_samples | input | NCH*32 | Channel c in bits [32c+31:32c], signed |
| cfg_gain | input | 32 | Shared gain, signed, 27 fraction bits |
| cfg_gain_en | input | 1 | 1 applies `cfg_gain`, 0 uses 1.0 |
| cfg_trim | input | NCH*32 | Trim for channel c in bits [32c+31:32c], unsigned, 31 fraction bits |
| cfg_mute | input | 1 | 1 silences all slots |
| cfg_remap_en | input | 1 | 1 routes slots by selector, 0 routes in order |
| cfg_route | input | NSLOT*4 | Channel selector for slot k in bits [4k+3:4k] |
| cfg_dual_mono | input | 2 | Dual-mono code 0 to 3 |
| out_valid | output | 1 | Output frame strobe |
| out_samples | output | NSLOT*32 | Slot k in bits [32k+31:32k], signed |

## Verification
The hardest situation to reach from the ports is a settings change racing a frame that is already inside the pipeline. Only the capture edge may decide what that frame sees. The bench launches a frame, then rewrites mute, gain and routing on the next falling edge while the frame is still two stages from the output. It checks that the output still reflects the old settings and that the following frame reflects the new ones. Saturation and round-half-up cases are reached with chosen extreme samples and gains whose exact products land on the limits and on halves.

// File: rtl/ctr_pkg.sv
// Shared constants, types and the round/saturate helper for the gain,
// trim and slot router. Assumes 32-bit samples, a signed gain with
// 27 fraction bits and an unsigned trim with 31 fraction bits.
package ctr_pkg;
    localparam int SAMPLE_W  = 32;
    localparam int GAIN_W    = 32;
    localparam int TRIM_W    = 32;
    localparam int GAIN_FRAC = 27;
    localparam int TRIM_FRAC = 31;
    localparam int PROD_W    = SAMPLE_W + GAIN_W + TRIM_W + 1;
    localparam int SHIFT     = GAIN_FRAC + TRIM_FRAC;

    // Fixed roles of internal channels used by the dual-mono stage
    localparam int CH_L = 0;
    localparam int CH_C = 1;
    localparam int CH_R = 2;

    localparam logic signed [GAIN_W-1:0] GAIN_ONE = 32'sh0800_0000;

    typedef enum logic [1:0] {
        DM_STEREO = 2'd0,
        DM_LEFT   = 2'd1,
        DM_RIGHT  = 2'd2,
        DM_MIX    = 2'd3
    } dm_mode_e;

    // Round half upward at SHIFT fraction bits, then clamp to a signed sample
    function automatic logic signed [SAMPLE_W-1:0] round_sat(
        input logic signed [PROD_W-1:0] v);
        logic signed [PROD_W-1:0] half;
        logic signed [PROD_W-1:0] r;
        logic signed [PROD_W-1:0] hi;
        logic signed [PROD_W-1:0] lo;
        half = '0;
        half[SHIFT-1] = 1'b1;
        r  = (v + half) >>> SHIFT;
        hi = '0;
        hi[SAMPLE_W-2:0] = '1;
        lo = ~hi;
        if (r > hi)      return hi[SAMPLE_W-1:0];
        else if (r < lo) return lo[SAMPLE_W-1:0];
        else             return r[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/dm_capture.sv
// Stage A: captures one input frame and all settings on the frame strobe.
// The dual-mono substitution on the left/center/right channels happens
// here. Assumes NCH >= 3 so that channels 0, 1 and 2 exist.
module dm_capture
    import ctr_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSLOT = 8,
    parameter int SELW  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NCH*SAMPLE_W-1:0]   in_samples,
    input  logic [GAIN_W-1:0]         cfg_gain,
    input  logic                      cfg_gain_en,
    input  logic [NCH*TRIM_W-1:0]     cfg_trim,
    input  logic                      cfg_mute,
    input  logic                      cfg_remap_en,
    input  logic [NSLOT*SELW-1:0]     cfg_route,
    input  logic [1:0]                cfg_dual_mono,
    output logic                      va,
    output logic [NCH*SAMPLE_W-1:0]   ch_a,
    output logic [GAIN_W-1:0]         gain_a,
    output logic [NCH*TRIM_W-1:0]     trim_a,
    output logic                      mute_a,
    output logic                      remap_a,
    output logic [NSLOT*SELW-1:0]     route_a
);
    logic [NCH*SAMPLE_W-1:0] ch_dm;
    logic signed [SAMPLE_W-1:0] left_in, right_in;
    logic signed [SAMPLE_W:0]   pair_sum;
    dm_mode_e mode;

    assign left_in  = in_samples[CH_L*SAMPLE_W +: SAMPLE_W];
    assign right_in = in_samples[CH_R*SAMPLE_W +: SAMPLE_W];
    assign mode     = dm_mode_e'(cfg_dual_mono);

    // Widened sum so the average of two extremes cannot wrap
    assign pair_sum = (SAMPLE_W+1)'(left_in) + (SAMPLE_W+1)'(right_in);

    // Substitute the center feed and silence left/right in dual-mono codes
    always_comb begin
        ch_dm = in_samples;
        if (mode != DM_STEREO) begin
            ch_dm[CH_L*SAMPLE_W +: SAMPLE_W] = '0;
            ch_dm[CH_R*SAMPLE_W +: SAMPLE_W] = '0;
        end
        case (mode)
            DM_LEFT:  ch_dm[CH_C*SAMPLE_W +: SAMPLE_W] = left_in;
            DM_RIGHT: ch_dm[CH_C*SAMPLE_W +: SAMPLE_W] = right_in;
            DM_MIX:   ch_dm[CH_C*SAMPLE_W +: SAMPLE_W] = pair_sum[SAMPLE_W:1];
            default:  ;
        endcase
    end

    // Capture the frame and the whole setting set only on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va      <= 1'b0;
            ch_a    <= '0;
            gain_a  <= GAIN_ONE;
            trim_a  <= '0;
            mute_a  <= 1'b0;
            remap_a <= 1'b0;
            route_a <= '0;
        end else begin
            va <= in_valid;
            if (in_valid) begin
                ch_a    <= ch_dm;
                gain_a  <= cfg_gain_en ? cfg_gain : GAIN_ONE;
                trim_a  <= cfg_trim;
                mute_a  <= cfg_mute;
                remap_a <= cfg_remap_en;
                route_a <= cfg_route;
            end
        end
    end

    // R10: dual-mono codes 1..3 leave left and right silent
    a_r10_lr_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_dual_mono != 2'd0) |=>
        (ch_a[CH_L*SAMPLE_W +: SAMPLE_W] == '0 && ch_a[CH_R*SAMPLE_W +: SAMPLE_W] == '0));

    // R10: code 1 carries the captured left sample onto the center
    a_r10_center_left: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_dual_mono == 2'd1) |=>
        (ch_a[CH_C*SAMPLE_W +: SAMPLE_W] == $past(in_samples[CH_L*SAMPLE_W +: SAMPLE_W])));

    // R11: settings are frozen between strobes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(gain_a) && $stable(trim_a) && $stable(mute_a)
                       && $stable(remap_a) && $stable(route_a)));
endmodule

// File: rtl/gain_trim_scale.sv
// Stage B: multiplies every captured channel by the gain and its own trim
// at full precision, rounds, saturates and applies mute. Routing settings
// travel alongside so stage C sees the same frame's values.
module gain_trim_scale
    import ctr_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSLOT = 8,
    parameter int SELW  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      va,
    input  logic [NCH*SAMPLE_W-1:0]   ch_a,
    input  logic [GAIN_W-1:0]         gain_a,
    input  logic [NCH*TRIM_W-1:0]     trim_a,
    input  logic                      mute_a,
    input  logic                      remap_a,
    input  logic [NSLOT*SELW-1:0]     route_a,
    output logic                      vb,
    output logic [NCH*SAMPLE_W-1:0]   ch_b,
    output logic                      remap_b,
    output logic [NSLOT*SELW-1:0]     route_b
);
    logic [NCH*SAMPLE_W-1:0] scaled;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic signed [SAMPLE_W-1:0]      x;
        logic signed [GAIN_W+SAMPLE_W-1:0] xg;
        logic signed [PROD_W-1:0]        full;
        logic signed [PROD_W-1:0]        trim_ext;

        assign x        = ch_a[c*SAMPLE_W +: SAMPLE_W];
        assign xg       = (GAIN_W+SAMPLE_W)'(x) * (GAIN_W+SAMPLE_W)'($signed(gain_a));
        assign trim_ext = $signed({{(PROD_W-TRIM_W){1'b0}}, trim_a[c*TRIM_W +: TRIM_W]});

        // Exact sample*gain*trim product, then one rounding step
        always_comb begin
            full = PROD_W'(xg) * trim_ext;
            scaled[c*SAMPLE_W +: SAMPLE_W] = mute_a ? '0 : round_sat(full);
        end
    end

    // Register scaled channels with the routing settings of the same frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb      <= 1'b0;
            ch_b    <= '0;
            remap_b <= 1'b0;
            route_b <= '0;
        end else begin
            vb <= va;
            if (va) begin
                ch_b    <= scaled;
                remap_b <= remap_a;
                route_b <= route_a;
            end
        end
    end

    // R7: a muted frame leaves this stage as all zeros
    a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (va && mute_a) |=> (ch_b == '0));

    // R2: this stage adds exactly one cycle of delay
    a_r2_stage_b: assert property (@(posedge clk) disable iff (!rst_n)
        va |=> vb);
endmodule

// File: rtl/slot_router.sv
// Stage C: fills each output slot from a selected scaled channel, or in
// channel order when remapping is off. A selector at or above NCH yields
// silence; slots beyond NCH in order mode are silent as well.
module slot_router
    import ctr_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSLOT = 8,
    parameter int SELW  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vb,
    input  logic [NCH*SAMPLE_W-1:0]   ch_b,
    input  logic                      remap_b,
    input  logic [NSLOT*SELW-1:0]     route_b,
    output logic                      out_valid,
    output logic [NSLOT*SAMPLE_W-1:0] out_samples
);
    logic [NSLOT*SAMPLE_W-1:0] routed;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [SELW-1:0] sel;
        assign sel = route_b[k*SELW +: SELW];

        // Pick this slot's source channel
        always_comb begin
            routed[k*SAMPLE_W +: SAMPLE_W] = '0;
            if (remap_b) begin
                if (int'(sel) < NCH)
                    routed[k*SAMPLE_W +: SAMPLE_W] = ch_b[int'(sel)*SAMPLE_W +: SAMPLE_W];
            end else if (k < NCH) begin
                routed[k*SAMPLE_W +: SAMPLE_W] = ch_b[(k % NCH)*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    // Output register for the routed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_samples <= '0;
        end else begin
            out_valid <= vb;
            if (vb) out_samples <= routed;
        end
    end

    // R2: output strobe follows stage B by one cycle
    a_r2_stage_c: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(vb));

    // R9: in order mode slot 0 equals scaled channel 0
    a_r9_slot0_inorder: assert property (@(posedge clk) disable iff (!rst_n)
        (vb && !remap_b) |=> (out_samples[SAMPLE_W-1:0] == $past(ch_b[SAMPLE_W-1:0])));
endmodule

// File: rtl/chan_trim_router.sv
// Top of the gain, trim and slot router: capture with dual-mono (A),
// scale/round/saturate/mute (B), slot routing (C). Three cycles from
// frame strobe to output strobe. Assumes NSLOT*4 selector bits with
// 4-bit selectors sized from NCH.
module chan_trim_router
    import ctr_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSLOT = 8,
    localparam int SELW = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NCH*SAMPLE_W-1:0]   in_samples,
    input  logic [GAIN_W-1:0]         cfg_gain,
    input  logic                      cfg_gain_en,
    input  logic [NCH*TRIM_W-1:0]     cfg_trim,
    input  logic                      cfg_mute,
    input  logic                      cfg_remap_en,
    input  logic [NSLOT*SELW-1:0]     cfg_route,
    input  logic [1:0]                cfg_dual_mono,
    output logic                      out_valid,
    output logic [NSLOT*SAMPLE_W-1:0] out_samples
);
    logic                    va, vb;
    logic [NCH*SAMPLE_W-1:0] ch_a, ch_b;
    logic [GAIN_W-1:0]       gain_a;
    logic [NCH*TRIM_W-1:0]   trim_a;
    logic                    mute_a, remap_a, remap_b;
    logic [NSLOT*SELW-1:0]   route_a, route_b;

    dm_capture #(.NCH(NCH), .NSLOT(NSLOT), .SELW(SELW)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .cfg_gain(cfg_gain), .cfg_gain_en(cfg_gain_en), .cfg_trim(cfg_trim),
        .cfg_mute(cfg_mute), .cfg_remap_en(cfg_remap_en), .cfg_route(cfg_route),
        .cfg_dual_mono(cfg_dual_mono), .va(va), .ch_a(ch_a), .gain_a(gain_a),
        .trim_a(trim_a), .mute_a(mute_a), .remap_a(remap_a), .route_a(route_a)
    );

    gain_trim_scale #(.NCH(NCH), .NSLOT(NSLOT), .SELW(SELW)) u_scale (
        .clk(clk), .rst_n(rst_n), .va(va), .ch_a(ch_a), .gain_a(gain_a),
        .trim_a(trim_a), .mute_a(mute_a), .remap_a(remap_a), .route_a(route_a),
        .vb(vb), .ch_b(ch_b), .remap_b(remap_b), .route_b(route_b)
    );

    slot_router #(.NCH(NCH), .NSLOT(NSLOT), .SELW(SELW)) u_route (
        .clk(clk), .rst_n(rst_n), .vb(vb), .ch_b(ch_b), .remap_b(remap_b),
        .route_b(route_b), .out_valid(out_valid), .out_samples(out_samples)
    );

    // R1: reset clears the output strobe and samples
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_samples == '0));

    // R2: capture stage strobe follows the input strobe
    a_r2_stage_a: assert property (@(posedge clk) disable iff (!rst_n)
        va == $past(in_valid));
endmodule

// File: tb/chan_trim_router_test.sv
// Directed bench: one task per scenario, each checking its own slots.
module chan_trim_router_test;
    localparam int NCH   = 16;
    localparam int NSLOT = 8;
    localparam int SW    = 32;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  in_valid;
    logic [NCH*SW-1:0]     in_samples;
    logic [31:0]           cfg_gain;
    logic                  cfg_gain_en;
    logic [NCH*32-1:0]     cfg_trim;
    logic                  cfg_mute;
    logic                  cfg_remap_en;
    logic [NSLOT*4-1:0]    cfg_route;
    logic [1:0]            cfg_dual_mono;
    logic                  out_valid;
    logic [NSLOT*SW-1:0]   out_samples;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    chan_trim_router #(.NCH(NCH), .NSLOT(NSLOT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .cfg_gain(cfg_gain), .cfg_gain_en(cfg_gain_en), .cfg_trim(cfg_trim),
        .cfg_mute(cfg_mute), .cfg_remap_en(cfg_remap_en), .cfg_route(cfg_route),
        .cfg_dual_mono(cfg_dual_mono), .out_valid(out_valid), .out_samples(out_samples)
    );

    function automatic logic [31:0] slot(input int k);
        return out_samples[k*SW +: SW];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic set_ch(input int c, input logic [31:0] v);
        in_samples[c*SW +: SW] = v;
    endtask

    task automatic set_trim(input int c, input logic [31:0] v);
        cfg_trim[c*32 +: 32] = v;
    endtask

    // Unity settings, in-order routing, identity channel contents
    task automatic defaults();
        cfg_gain      = 32'h0800_0000;
        cfg_gain_en   = 1'b1;
        cfg_mute      = 1'b0;
        cfg_remap_en  = 1'b0;
        cfg_dual_mono = 2'd0;
        cfg_route     = '0;
        for (int c = 0; c < NCH; c++) begin
            set_trim(c, 32'h8000_0000);
            set_ch(c, 32'(c * 111 + 5));
        end
    endtask

    // Strobe one frame, then wait until the third edge has produced it
    task automatic run_frame();
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_samples = '0; cfg_trim = '0;
        defaults();
        repeat (5) @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 32'd0);
        for (int k = 0; k < NSLOT; k++) check("R1 slot zero in reset", slot(k), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unity_inorder();
        defaults();
        cfg_route = {8{4'd9}};          // ignored while remap is off (R9)
        run_frame();
        check("R2 out_valid on third edge", 32'(out_valid), 32'd1);
        for (int k = 0; k < NSLOT; k++) check("R9 in-order slot", slot(k), 32'(k * 111 + 5));
        @(negedge clk);
        check("R2 single pulse", 32'(out_valid), 32'd0);
    endtask

    task automatic t_trim_round();
        defaults();
        set_ch(0, 32'd1000);  set_trim(0, 32'h4000_0000);
        set_ch(1, 32'd3);     set_trim(1, 32'h4000_0000);
        set_ch(2, -32'sd3);   set_trim(2, 32'h4000_0000);
        set_ch(3, 32'd12345); set_trim(3, 32'h0000_0000);
        set_ch(4, -32'sd777); set_trim(4, 32'h8000_0000);
        run_frame();
        check("R3 trim half", slot(0), 32'd500);
        check("R3 round half up +1.5", slot(1), 32'd2);
        check("R3 round half up -1.5", slot(2), 32'hFFFF_FFFF);
        check("R3 trim zero", slot(3), 32'd0);
        check("R3 trim one", slot(4), -32'sd777);
    endtask

    task automatic t_neg_gain();
        defaults();
        cfg_gain = 32'hF800_0000;
        set_ch(0, 32'd1000);
        set_ch(1, -32'sd5);
        run_frame();
        check("R4 invert positive", slot(0), -32'sd1000);
        check("R4 invert negative", slot(1), 32'd5);
    endtask

    task automatic t_saturate();
        defaults();
        cfg_gain = 32'h1000_0000;       // 2.0
        set_ch(0, 32'h4000_0000);
        set_ch(1, 32'hC000_0000);
        set_ch(2, 32'hA000_0000);
        set_ch(3, 32'd100);
        run_frame();
        check("R5 clamp high", slot(0), 32'h7FFF_FFFF);
        check("R5 exact minimum", slot(1), 32'h8000_0000);
        check("R5 clamp low", slot(2), 32'h8000_0000);
        check("R5 in range", slot(3), 32'd200);
    endtask

    task automatic t_gain_bypass();
        defaults();
        cfg_gain_en = 1'b0;
        cfg_gain    = 32'h0000_0000;    // would silence if applied
        set_ch(0, 32'd1000); set_trim(0, 32'h4000_0000);
        set_ch(1, 32'h7FFF_FFFF);
        run_frame();
        check("R6 bypass keeps trim", slot(0), 32'd500);
        check("R6 bypass unity", slot(1), 32'h7FFF_FFFF);
    endtask

    task automatic t_mute();
        defaults();
        cfg_mute = 1'b1;
        run_frame();
        for (int k = 0; k < NSLOT; k++) check("R7 muted slot", slot(k), 32'd0);
        cfg_mute = 1'b0;
        run_frame();
        check("R7 unmuted again", slot(5), 32'(5 * 111 + 5));
    endtask

    task automatic t_route();
        int map [NSLOT] = '{0, 2, 3, 4, 1, 7, 5, 6};
        defaults();
        cfg_remap_en = 1'b1;
        for (int k = 0; k < NSLOT; k++) cfg_route[k*4 +: 4] = 4'(map[k]);
        run_frame();
        for (int k = 0; k < NSLOT; k++) check("R8 selected slot", slot(k), 32'(map[k] * 111 + 5));
        cfg_route = {8{4'd15}};
        run_frame();
        for (int k = 0; k < NSLOT; k++) check("R8 shared channel", slot(k), 32'(15 * 111 + 5));
    endtask

    task automatic t_dual_mono();
        defaults();
        set_ch(0, 32'd1000); set_ch(1, 32'd7); set_ch(2, -32'sd3001);
        cfg_dual_mono = 2'd0; run_frame();
        check("R10 code0 left", slot(0), 32'd1000);
        check("R10 code0 center", slot(1), 32'd7);
        check("R10 code0 right", slot(2), -32'sd3001);
        cfg_dual_mono = 2'd1; run_frame();
        check("R10 code1 left", slot(0), 32'd0);
        check("R10 code1 center", slot(1), 32'd1000);
        check("R10 code1 right", slot(2), 32'd0);
        cfg_dual_mono = 2'd2; run_frame();
        check("R10 code2 center", slot(1), -32'sd3001);
        check("R10 code2 left", slot(0), 32'd0);
        cfg_dual_mono = 2'd3; run_frame();
        check("R10 code3 center floor", slot(1), -32'sd1001);
        check("R10 code3 right", slot(2), 32'd0);
        set_ch(0, 32'h7FFF_FFFF); set_ch(2, 32'h7FFF_FFFF);
        run_frame();
        check("R10 code3 no overflow", slot(1), 32'h7FFF_FFFF);
    endtask

    task automatic t_hold();
        defaults();
        set_ch(3, 32'd4242);
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        cfg_mute = 1'b1; cfg_gain = 32'h0; cfg_remap_en = 1'b1; cfg_route = '0;
        @(negedge clk);
        @(negedge clk);
        check("R11 in-flight slot3 keeps old", slot(3), 32'd4242);
        check("R11 in-flight strobe", 32'(out_valid), 32'd1);
        // back-to-back frames with new settings
        cfg_mute = 1'b0; cfg_gain = 32'h0800_0000; cfg_remap_en = 1'b0;
        @(negedge clk); in_valid = 1'b1; set_ch(0, 32'd11);
        @(negedge clk); set_ch(0, 32'd22); cfg_gain = 32'hF800_0000;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R2 first of pair", slot(0), 32'd11);
        @(negedge clk);
        check("R2 second of pair", slot(0), -32'sd22);
        check("R2 second strobe", 32'(out_valid), 32'd1);
    endtask

    initial begin
        t_reset();
        t_unity_inorder();
        t_trim_round();
        t_neg_gain();
        t_saturate();
        t_gain_bypass();
        t_mute();
        t_route();
        t_dual_mono();
        t_hold();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule